// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit executes the register-form conditional select family of a 64-bit integer pipeline. Each cycle it takes one 32-bit instruction word, the two operand values already read from the register file for the instruction's two source fields, and the current four condition flags. One clock later it presents the value to write back, the destination index, a write enable and an undefined-instruction indication.

If the encoded condition holds on the flags, the first source value is passed through. If it does not hold, the second source value goes through an else-path of two independent steps: an optional bitwise inversion, then an optional increment by one. With neither, one or both steps enabled, the same datapath gives plain select, select-increment, select-invert and select-negate. A size bit selects 64-bit or 32-bit operation. In 32-bit operation the result is zero-extended from its low 32 bits. A source index of 31 denotes the zero register, and a destination index of 31 discards the result.

Top module: `csel_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `rd_o`, `wr_en_o` and `undef_o` all become zero.
- R2: Outputs are registered. They reflect the inputs sampled at the previous rising edge and do not change between edges.
- R3: An instruction is legal only when bits 29:21 equal 9'h0D4 and bit 11 is 0. Otherwise `undef_o` is 1 and `wr_en_o`, `result_o` and `rd_o` are 0.
- R4: Field positions are: bit 31 is the size flag (1 = 64-bit); bit 30 is invert; bit 10 is increment; bits 20:16 are the second source index; bits 15:12 are the condition; bits 9:5 are the first source index; bits 4:0 are the destination index, which is copied to `rd_o`.
- R5: `flags_i` is {N,Z,C,V} from bit 3 down to bit 0. Conditions evaluate in pairs: 0/1 test Z; 2/3 test C; 4/5 test N; 6/7 test V; 8/9 test C and not Z; 10/11 test N equal to V; 12/13 test not Z and N equal to V. An odd code gives the opposite outcome of its even partner.
- R6: Condition codes 14 and 15 always hold and select the first source.
- R7: On a failed condition, the result is the second source, inverted if the invert bit is 1, then incremented by one if the increment bit is 1. With both bits set, the result is the two's-complement negation of the second source.
- R8: With the size flag at 0, `result_o[63:32]` is zero on every legal instruction. This holds for both paths, including a wrap of the increment.
- R9: A source index of 31 reads as zero, whatever value is on the matching operand input.
- R10: A legal instruction whose destination index is 31 drives `wr_en_o` low. Any other legal instruction drives it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| op_a_i | input | 64 | Value read for the first source index |
| op_b_i | input | 64 | Value read for the second source index |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| result_o | output | 64 | Value to write back |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back enable |
| undef_o | output | 1 | Instruction encoding is undefined |

## Verification
Several properties are checked on every cycle against the inputs of the previous edge. These are: the legality rule and its side effects on the other outputs, the suppression of writes to index 31, the destination copy, the zero upper half in 32-bit operation, and pass-through of the first source for the always conditions. The full condition table, the invert-then-increment order with its wrap at zero and all ones, and the zero-register substitution on each source are shown only by the bench. The bench sweeps every condition code against every flag combination, in both sizes, with all four else-path controls, and compares each result with an arithmetic model.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;
    localparam logic [8:0]       FIXED_PATTERN = 9'h0D4;
    localparam logic [IDX_W-1:0] ZERO_IDX      = '1;

    // Condition codes are evaluated as pairs selected by the upper three bits.
    typedef enum logic [2:0] {
        PAIR_ZERO    = 3'd0,
        PAIR_CARRY   = 3'd1,
        PAIR_NEG     = 3'd2,
        PAIR_OVF     = 3'd3,
        PAIR_UHIGHER = 3'd4,
        PAIR_SGE     = 3'd5,
        PAIR_SGT     = 3'd6,
        PAIR_ALWAYS  = 3'd7
    } cond_pair_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              legal;
        logic              wide;
        logic              inv;
        logic              inc;
        logic [COND_W-1:0] cond;
        logic [IDX_W-1:0]  src1;
        logic [IDX_W-1:0]  src2;
        logic [IDX_W-1:0]  dst;
    } csel_dec_t;

    function automatic logic pair_true(input cond_pair_e p, input flags_t f);
        logic r;
        unique case (p)
            PAIR_ZERO:    r = f.z;
            PAIR_CARRY:   r = f.c;
            PAIR_NEG:     r = f.n;
            PAIR_OVF:     r = f.v;
            PAIR_UHIGHER: r = f.c & ~f.z;
            PAIR_SGE:     r = ~(f.n ^ f.v);
            PAIR_SGT:     r = ~f.z & ~(f.n ^ f.v);
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic cond_true(input logic [COND_W-1:0] code, input flags_t f);
        logic base;
        base = pair_true(cond_pair_e'(code[COND_W-1:1]), f);
        if (code[COND_W-1:1] == 3'b111) begin
            return 1'b1;
        end
        return base ^ code[0];
    endfunction

endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output csel_dec_t         dec
);

    logic [8:0] fixed_bits;
    logic       reserved_bit;

    assign fixed_bits   = insn[29:21];
    assign reserved_bit = insn[11];

    always_comb begin
        dec       = '0;
        dec.legal = (fixed_bits == FIXED_PATTERN) && !reserved_bit;
        dec.wide  = insn[31];
        dec.inv   = insn[30];
        dec.src2  = insn[20:16];
        dec.cond  = insn[15:12];
        dec.inc   = insn[10];
        dec.src1  = insn[9:5];
        dec.dst   = insn[4:0];
    end

endmodule

// File: rtl/csel_cond.sv
module csel_cond
    import csel_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic [FLAG_W-1:0] flags,
    output logic              hold
);

    flags_t f;

    assign f    = flags_t'(flags);
    assign hold = cond_true(code, f);

endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
    import csel_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  csel_dec_t        dec,
    input  logic             hold,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    output logic [XLEN-1:0]  res
);

    localparam int PAD_W = XLEN - NARROW_W;

    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] b_inv;
    logic [XLEN-1:0] b_step;
    logic [XLEN-1:0] picked;

    // Zero register substitution on both sources
    assign a_eff = (dec.src1 == ZERO_IDX) ? '0 : op_a;
    assign b_eff = (dec.src2 == ZERO_IDX) ? '0 : op_b;

    // Else path: inversion first, then increment
    assign b_inv  = dec.inv ? ~b_eff : b_eff;
    assign b_step = b_inv + {{(XLEN-1){1'b0}}, dec.inc};

    assign picked = hold ? a_eff : b_step;

    generate
        if (PAD_W > 0) begin : g_narrow
            assign res = dec.wide ? picked
                                  : {{PAD_W{1'b0}}, picked[NARROW_W-1:0]};
        end else begin : g_full
            assign res = picked;
        end
    endgenerate

endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   op_a_i,
    input  logic [XLEN-1:0]   op_b_i,
    input  logic [3:0]        flags_i,
    output logic [XLEN-1:0]   result_o,
    output logic [4:0]        rd_o,
    output logic              wr_en_o,
    output logic              undef_o
);

    csel_dec_t       dec;
    logic            hold;
    logic [XLEN-1:0] res_d;

    csel_decode u_decode (
        .insn (instr_i),
        .dec  (dec)
    );

    csel_cond u_cond (
        .code  (dec.cond),
        .flags (flags_i),
        .hold  (hold)
    );

    csel_datapath #(
        .XLEN     (XLEN),
        .NARROW_W (NARROW_W)
    ) u_dp (
        .dec  (dec),
        .hold (hold),
        .op_a (op_a_i),
        .op_b (op_b_i),
        .res  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            rd_o     <= '0;
            wr_en_o  <= 1'b0;
            undef_o  <= 1'b0;
        end else if (dec.legal) begin
            result_o <= res_d;
            rd_o     <= dec.dst;
            wr_en_o  <= (dec.dst != ZERO_IDX);
            undef_o  <= 1'b0;
        end else begin
            result_o <= '0;
            rd_o     <= '0;
            wr_en_o  <= 1'b0;
            undef_o  <= 1'b1;
        end
    end

endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] op_a_i,
    input logic [XLEN-1:0] op_b_i,
    input logic [3:0]      flags_i,
    input logic [XLEN-1:0] result_o,
    input logic [4:0]      rd_o,
    input logic            wr_en_o,
    input logic            undef_o
);

    logic in_legal;
    assign in_legal = (instr_i[29:21] == 9'h0D4) && (instr_i[11] == 1'b0);

    // R3
    undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !in_legal |=> (undef_o && !wr_en_o && result_o == '0));

    // R3
    legal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        in_legal |=> !undef_o);

    // R10
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (in_legal && instr_i[4:0] == 5'd31) |=> !wr_en_o);

    // R4
    dst_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_legal && instr_i[4:0] != 5'd31) |=> (wr_en_o && rd_o == $past(instr_i[4:0])));

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_legal && !instr_i[31]) |=> (result_o[XLEN-1:32] == '0));

    // R6
    always_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_legal && instr_i[31] && instr_i[15:13] == 3'b111 && instr_i[9:5] != 5'd31)
        |=> (result_o == $past(op_a_i)));

endmodule

bind csel_unit csel_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .instr_i  (instr_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .rd_o     (rd_o),
    .wr_en_o  (wr_en_o),
    .undef_o  (undef_o)
);

// File: tb/csel_unit_bench.sv
`timescale 1ns/1ps
module csel_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = '0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [3:0]  flags_i = '0;
    logic [63:0] result_o;
    logic [4:0]  rd_o;
    logic        wr_en_o;
    logic        undef_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    csel_unit u_csel_unit (
        .clk      (clk),
        .rst      (rst),
        .instr_i  (instr_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .rd_o     (rd_o),
        .wr_en_o  (wr_en_o),
        .undef_o  (undef_o)
    );

    function automatic logic [31:0] mk(input bit sf, input bit inv, input bit inc,
                                       input logic [4:0] rm, input logic [3:0] cond,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {sf, inv, 1'b0, 8'b1101_0100, rm, cond, 1'b0, inc, rn, rd};
    endfunction

    // Model from R5/R6: flags are {N,Z,C,V}
    function automatic bit model_cond(input int code, input logic [3:0] fl);
        bit n, z, c, v, r;
        n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
        if (code >= 14) return 1;
        case (code / 2)
            0: r = z;
            1: r = c;
            2: r = n;
            3: r = v;
            4: r = c && !z;
            5: r = (n == v);
            default: r = !z && (n == v);
        endcase
        return (code % 2 == 1) ? !r : r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [63:0] a,
                         input logic [63:0] b, input logic [3:0] fl);
        @(negedge clk);
        instr_i = ins; op_a_i = a; op_b_i = b; flags_i = fl;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, e;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 result", result_o, 64'd0);
        check("R1 rd/wr/undef", {57'd0, rd_o, wr_en_o, undef_o}, 64'd0);
        rst = 1'b0;

        // R4 R5 R6 R7 R8 sweep
        for (int sf = 0; sf < 2; sf++) begin
            for (int ctl = 0; ctl < 4; ctl++) begin
                for (int cd = 0; cd < 16; cd++) begin
                    for (int fl = 0; fl < 16; fl++) begin
                        a = 64'hA5C3_0F1E_8000_0001 ^ (64'(cd) << 40) ^ 64'(fl);
                        case (fl % 4)
                            0: b = 64'd0;
                            1: b = 64'hFFFF_FFFF_FFFF_FFFF;
                            2: b = 64'h0000_0001_FFFF_FFFF;
                            default: b = 64'h1234_5678_9ABC_DEF0 + 64'(cd);
                        endcase
                        apply(mk(sf[0], ctl[1], ctl[0], 5'd7, cd[3:0], 5'd3, 5'd12), a, b, fl[3:0]);
                        if (model_cond(cd, fl[3:0])) e = a;
                        else e = (ctl[1] ? (64'hFFFF_FFFF_FFFF_FFFF - b) : b) + 64'(ctl[0]);
                        if (sf == 0) e = {32'd0, e[31:0]};
                        check("R5/R6/R7/R8 result", result_o, e);
                        check("R4 rd/wr", {58'd0, rd_o, wr_en_o}, {58'd0, 5'd12, 1'b1});
                    end
                end
            end
        end

        // R7 negation explicit: cond EQ with Z=0 fails
        apply(mk(1'b1, 1'b1, 1'b1, 5'd2, 4'd0, 5'd1, 5'd4), 64'd9, 64'd5, 4'b0000);
        check("R7 negate", result_o, 64'hFFFF_FFFF_FFFF_FFFB);

        // R9 zero register sources
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd31, 5'd4), 64'hDEAD_BEEF_0000_1111, 64'd5, 4'b0000);
        check("R9 src1 zero", result_o, 64'd0);
        apply(mk(1'b1, 1'b1, 1'b0, 5'd31, 4'd0, 5'd1, 5'd4), 64'd1, 64'h7777_7777_7777_7777, 4'b0000);
        check("R9 src2 zero invert", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(mk(1'b1, 1'b1, 1'b1, 5'd31, 4'd0, 5'd1, 5'd4), 64'd1, 64'h7777_7777_7777_7777, 4'b0000);
        check("R9 src2 zero negate", result_o, 64'd0);
        apply(mk(1'b0, 1'b1, 1'b0, 5'd31, 4'd0, 5'd1, 5'd4), 64'd1, 64'h7777_7777_7777_7777, 4'b0000);
        check("R9 R8 src2 zero narrow", result_o, 64'h0000_0000_FFFF_FFFF);

        // R10 destination 31
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd31), 64'd77, 64'd5, 4'b0000);
        check("R10 wr_en", {63'd0, wr_en_o}, 64'd0);
        check("R10 undef", {63'd0, undef_o}, 64'd0);

        // R3 undefined encodings
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd4) | 32'h0000_0800, 64'd77, 64'd5, 4'b0000);
        check("R3 bit11", {56'd0, undef_o, wr_en_o, rd_o, 1'b0}, {56'd0, 1'b1, 1'b0, 5'd0, 1'b0});
        check("R3 bit11 result", result_o, 64'd0);
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd4) | 32'h2000_0000, 64'd77, 64'd5, 4'b0000);
        check("R3 bit29", {62'd0, undef_o, wr_en_o}, 64'd2);
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd4) ^ 32'h0020_0000, 64'd77, 64'd5, 4'b0000);
        check("R3 bit21", {62'd0, undef_o, wr_en_o}, 64'd2);
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd4), 64'd77, 64'd5, 4'b0000);
        check("R3 legal again", {62'd0, undef_o, wr_en_o}, 64'd1);

        // R2 outputs hold between edges
        apply(mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd4), 64'h1111, 64'd5, 4'b0000);
        instr_i = mk(1'b1, 1'b0, 1'b0, 5'd2, 4'd14, 5'd1, 5'd9);
        op_a_i  = 64'h2222;
        #1;
        check("R2 hold result", result_o, 64'h1111);
        check("R2 hold rd", {59'd0, rd_o}, 64'd4);
        @(negedge clk);
        check("R2 next edge", result_o, 64'h2222);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {result_o[62:0], wr_en_o}, 64'd0);
        rst = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule